// File: doc/BRIEF.md
# Hall Sensor Commutation Decoder

This block turns the three Hall sensor signals of a brushless DC motor, whose sensors sit 120 electrical degrees apart, into the six bridge gate enables that select which phase is pulled high and which is pulled low. It is the six-step sequencer that sits in front of the gate drivers. Decay and chopping logic downstream then masks these enables.

The Hall lines first pass through a synchronizer. The synchronized code then drives a registered six-step table. The table's sense flips with a direction input. An active-low brake input shorts the windings through the low-side switches. A coast request turns every switch off and wins over braking. Codes 000 and 111 are treated as a sensor fault: the bridge coasts and a flag is raised.

Every change of the synchronized code produces a tachometer pulse of fixed length. A change to a legal code also produces a one-cycle commutation strobe.

Top module: `hall_commutator`

## Requirements
- R1: The Hall code is {H1,H2,H3} on `hall_in[2:0]`, with H1 in bit 2. Gate vectors use bit 0 for phase A, bit 1 for phase B and bit 2 for phase C. With `dir_fwd`=1, the (high, low) phases are: 101 gives (A,C), 100 gives (B,C), 110 gives (B,A), 010 gives (C,A), 011 gives (C,B) and 001 gives (A,B).
- R2: With `dir_fwd`=0, every legal code swaps the high and low phases of R1. For example, 101 gives C high and A low.
- R3: In normal drive, exactly one high-side and one low-side enable are set, on different phases. The remaining phase has both enables clear. No phase ever has both enables set.
- R4: Codes 000 and 111 set `hall_invalid` and clear all six enables, even while braking. They give no commutation strobe.
- R5: `coast_req`=1 clears all six enables. It overrides both brake and the table.
- R6: With `brake_n`=0, a legal code and no coast request, all three low-side enables are set and all high-side enables are clear.
- R7: `commute_stb` is high for one cycle when the synchronized code changes to a legal value. Brake and coast do not mask it.
- R8: `tach_pulse` is high for exactly TACH_CYCLES cycles after every change of the synchronized code, including a change to an illegal code. A new change during a pulse restarts the count.
- R9: A change on `hall_in` shows at the outputs after the third rising edge. A change on `dir_fwd`, `brake_n` or `coast_req` shows after the next rising edge.
- R10: While `rst` is high, and until the synchronizer has filled after reset, all outputs are zero. The first sampled code produces no strobe and no tachometer pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Raw Hall lines {H1,H2,H3} |
| dir_fwd | input | 1 | Rotation sense, 1 selects the R1 table |
| brake_n | input | 1 | Active-low dynamic brake |
| coast_req | input | 1 | Forces all gates off |
| gate_hi | output | 3 | High-side enables, bit 0 is phase A |
| gate_lo | output | 3 | Low-side enables, bit 0 is phase A |
| commute_stb | output | 1 | One-cycle strobe on a legal code change |
| tach_pulse | output | 1 | Stretched pulse on any code change |
| hall_invalid | output | 1 | Synchronized code is 000 or 111 |

## Verification
A corrupted previous-code register would show either as a missing strobe and tachometer pulse on the third edge after a Hall change, or as a spurious one on a cycle with no change. A wrong table entry or a wrong priority between coast, fault and brake shows on the gate enables one edge after the control input moves, or three edges after the Hall code moves. A miscounting pulse stretcher shows as a tachometer pulse that ends one cycle early or one cycle late. The bench therefore samples each output at the exact edge where it must change, and again one edge before and one edge after.

// File: rtl/hall_comm_pkg.sv
package hall_comm_pkg;

    typedef logic [2:0] hall_code_t;

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
    } gate_set_t;

    localparam gate_set_t GATES_OFF   = '{hi: 3'b000, lo: 3'b000};
    localparam gate_set_t GATES_BRAKE = '{hi: 3'b000, lo: 3'b111};

    function automatic logic code_is_legal(input hall_code_t c);
        return (c != 3'b000) && (c != 3'b111);
    endfunction

    // Forward six-step selection; reverse swaps the roles.
    function automatic gate_set_t drive_for_code(input hall_code_t c, input logic fwd);
        gate_set_t g;
        case (c)
            3'b101:  g = '{hi: 3'b001, lo: 3'b100};
            3'b100:  g = '{hi: 3'b010, lo: 3'b100};
            3'b110:  g = '{hi: 3'b010, lo: 3'b001};
            3'b010:  g = '{hi: 3'b100, lo: 3'b001};
            3'b011:  g = '{hi: 3'b100, lo: 3'b010};
            3'b001:  g = '{hi: 3'b001, lo: 3'b010};
            default: g = GATES_OFF;
        endcase
        if (!fwd) begin
            g = '{hi: g.lo, lo: g.hi};
        end
        return g;
    endfunction

endpackage

// File: rtl/hall_input_sync.sv
module hall_input_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out,
    output logic             d_valid
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [STAGES-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
            fill_q <= '0;
        end else begin
            stage_q[0] <= d_in;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
            fill_q <= {fill_q[STAGES-2:0], 1'b1};
        end
    end

    assign d_out   = stage_q[STAGES-1];
    assign d_valid = fill_q[STAGES-1];

    a_r10_fill_after_reset: assert property (@(posedge clk) disable iff (rst)
        d_valid |=> d_valid);
endmodule

// File: rtl/hall_step_table.sv
module hall_step_table
    import hall_comm_pkg::*;
(
    input  hall_code_t code,
    input  logic       code_vld,
    input  logic       fwd,
    input  logic       brake_n,
    input  logic       coast,
    output gate_set_t  gates,
    output logic       legal
);
    always_comb begin
        legal = code_is_legal(code);
        if (coast || !code_vld || !legal) begin
            gates = GATES_OFF;
        end else if (!brake_n) begin
            gates = GATES_BRAKE;
        end else begin
            gates = drive_for_code(code, fwd);
        end
    end

    always_comb begin
        a_r3_no_shoot_through: assert ((gates.hi & gates.lo) == 3'b000);
    end
endmodule

// File: rtl/tach_stretch.sv
module tach_stretch #(
    parameter int unsigned LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);
    localparam int unsigned CW = $clog2(LEN + 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= CW'(LEN);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse = (cnt_q != '0);

    a_r8_trigger_starts_pulse: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse);
endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hall_comm_pkg::*;
#(
    parameter int unsigned TACH_CYCLES = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_fwd,
    input  logic       brake_n,
    input  logic       coast_req,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       commute_stb,
    output logic       tach_pulse,
    output logic       hall_invalid
);
    hall_code_t hall_s, hall_prev_q;
    logic       sync_vld, prev_vld_q, code_legal, code_change;
    gate_set_t  gates_nxt, gates_q;

    hall_input_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .d_in(hall_in), .d_out(hall_s), .d_valid(sync_vld)
    );

    hall_step_table table_i (
        .code(hall_s), .code_vld(sync_vld), .fwd(dir_fwd), .brake_n(brake_n),
        .coast(coast_req), .gates(gates_nxt), .legal(code_legal)
    );

    assign code_change = prev_vld_q && (hall_s != hall_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hall_prev_q  <= '0;
            prev_vld_q   <= 1'b0;
            gates_q      <= GATES_OFF;
            commute_stb  <= 1'b0;
            hall_invalid <= 1'b0;
        end else begin
            hall_prev_q  <= hall_s;
            prev_vld_q   <= sync_vld;
            gates_q      <= gates_nxt;
            commute_stb  <= code_change && code_legal;
            hall_invalid <= sync_vld && !code_legal;
        end
    end

    tach_stretch #(.LEN(TACH_CYCLES)) tach_i (
        .clk(clk), .rst(rst), .trig(code_change), .pulse(tach_pulse)
    );

    assign gate_hi = gates_q.hi;
    assign gate_lo = gates_q.lo;

    a_r5_coast_overrides: assert property (@(posedge clk) disable iff (rst)
        coast_req |=> (gate_hi == 3'b000) && (gate_lo == 3'b000));

    a_r4_illegal_coasts: assert property (@(posedge clk) disable iff (rst)
        (sync_vld && !code_legal) |=> hall_invalid && !commute_stb &&
                                      (gate_hi == 3'b000) && (gate_lo == 3'b000));

    a_r6_brake_lows: assert property (@(posedge clk) disable iff (rst)
        (sync_vld && code_legal && !coast_req && !brake_n) |=>
            (gate_hi == 3'b000) && (gate_lo == 3'b111));

    a_r3_one_pair: assert property (@(posedge clk) disable iff (rst)
        (sync_vld && code_legal && !coast_req && brake_n) |=>
            ($countones(gate_hi) == 1) && ($countones(gate_lo) == 1) &&
            ((gate_hi & gate_lo) == 3'b000));

    a_r7_strobe_has_tach: assert property (@(posedge clk) disable iff (rst)
        commute_stb |-> tach_pulse && !hall_invalid);
endmodule

// File: tb/hall_commutator_tb.sv
`timescale 1ns/1ps
module hall_commutator_tb_top;
    localparam int TACH = 4;
    localparam logic [2:0] SEQ [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] hall_in = 3'b101;
    logic dir_fwd = 1'b1, brake_n = 1'b1, coast_req = 1'b0;
    logic [2:0] gate_hi, gate_lo;
    logic commute_stb, tach_pulse, hall_invalid;
    int vectors = 0, miscompares = 0;
    logic [2:0] cur;

    always #2 clk = ~clk;

    hall_commutator #(.TACH_CYCLES(TACH)) dut_i (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_fwd(dir_fwd), .brake_n(brake_n),
        .coast_req(coast_req), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .commute_stb(commute_stb), .tach_pulse(tach_pulse), .hall_invalid(hall_invalid)
    );

    function automatic logic [5:0] exp_gates(logic [2:0] c, logic fwd, logic bn, logic cs);
        int s = -1;
        int h, l;
        logic [2:0] hv, lv;
        if (cs || c == 3'b000 || c == 3'b111) return 6'b0;
        if (!bn) return {3'b000, 3'b111};
        for (int i = 0; i < 6; i++) if (SEQ[i] == c) s = i;
        h = ((s + 1) / 2) % 3;
        l = (s / 2 + 2) % 3;
        hv = 3'(1 << h);
        lv = 3'(1 << l);
        return fwd ? {hv, lv} : {lv, hv};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_gates(string req, logic [2:0] c);
        chk(req, {26'b0, gate_hi, gate_lo}, {26'b0, exp_gates(c, dir_fwd, brake_n, coast_req)});
    endtask

    initial begin
        #(200000 * 4);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        @(negedge clk);
        step(3);
        chk("R10 reset outputs", {gate_hi, gate_lo, commute_stb, tach_pulse, hall_invalid}, 0);
        rst = 1'b0;
        step(2);
        chk("R10 warmup outputs", {gate_hi, gate_lo, commute_stb, tach_pulse, hall_invalid}, 0);
        step(1);
        chk_gates("R1 first code", 3'b101);
        chk("R10 no first event", {commute_stb, tach_pulse}, 0);
        cur = 3'b101;

        // Sweep both directions through every legal code
        for (int d = 0; d < 2; d++) begin
            dir_fwd = (d == 0);
            step(1);
            chk_gates(d == 0 ? "R1 dir hold" : "R2 dir flip R9", cur);
            for (int k = 1; k <= 6; k++) begin
                logic [2:0] nc;
                nc = SEQ[k % 6];
                hall_in = nc;
                step(2);
                chk_gates("R9 old gates before third edge", cur);
                chk("R9 no early strobe", {31'b0, commute_stb}, 0);
                step(1);
                chk_gates(d == 0 ? "R1 table" : "R2 reversed table", nc);
                chk("R3 float phase", $countones(~(gate_hi | gate_lo)), 1);
                chk("R7 strobe", {31'b0, commute_stb}, 1);
                chk("R8 tach start", {31'b0, tach_pulse}, 1);
                chk("R4 legal flag", {31'b0, hall_invalid}, 0);
                step(1);
                chk("R7 strobe one cycle", {31'b0, commute_stb}, 0);
                step(TACH - 2);
                chk("R8 tach last cycle", {31'b0, tach_pulse}, 1);
                step(1);
                chk("R8 tach end", {31'b0, tach_pulse}, 0);
                cur = nc;
            end
        end

        // Illegal codes
        hall_in = 3'b000;
        step(3);
        chk("R4 invalid 000", {gate_hi, gate_lo, commute_stb, hall_invalid}, 8'b00000001);
        chk("R8 tach on illegal", {31'b0, tach_pulse}, 1);
        brake_n = 1'b0;
        step(1);
        chk("R4 illegal beats brake", {gate_hi, gate_lo}, 0);
        brake_n = 1'b1;
        hall_in = 3'b110;
        step(3);
        chk("R7 strobe after illegal", {commute_stb, hall_invalid}, 2'b10);
        chk_gates("R1 recovered", 3'b110);
        hall_in = 3'b111;
        step(3);
        chk("R4 invalid 111", {gate_hi, gate_lo, commute_stb, hall_invalid}, 8'b00000001);
        hall_in = 3'b110;
        step(3 + TACH);

        // Brake and coast priority
        brake_n = 1'b0;
        step(1);
        chk("R6 brake", {gate_hi, gate_lo}, 6'b000111);
        coast_req = 1'b1;
        step(1);
        chk("R5 coast over brake", {gate_hi, gate_lo}, 0);
        hall_in = 3'b010;
        step(3);
        chk("R5 coast holds", {gate_hi, gate_lo}, 0);
        chk("R7 strobe unmasked", {31'b0, commute_stb}, 1);
        coast_req = 1'b0;
        step(1);
        chk("R6 brake after coast", {gate_hi, gate_lo}, 6'b000111);
        brake_n = 1'b1;
        step(1);
        chk_gates("R9 brake release", 3'b010);
        step(TACH);

        // Retrigger of tach pulse
        hall_in = 3'b011;
        step(1);
        hall_in = 3'b001;
        step(2);
        chk("R8 first of pair", {commute_stb, tach_pulse}, 2'b11);
        step(1);
        chk("R7 second strobe", {commute_stb, tach_pulse}, 2'b11);
        chk_gates("R1 second code", 3'b001);
        step(TACH - 1);
        chk("R8 retrigger length", {31'b0, tach_pulse}, 1);
        step(1);
        chk("R8 retrigger end", {31'b0, tach_pulse}, 0);

        // Mid-run reset
        rst = 1'b1;
        step(1);
        chk("R10 mid-run reset", {gate_hi, gate_lo, commute_stb, tach_pulse, hall_invalid}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule